// File: doc/BRIEF.md
# Disk Controller Host Data Buffer

This block is the host-side byte buffer of a floppy-style disk controller. A host register port (read and write strobes, one data byte each way) talks to it on one side. A byte-serial disk data path talks to it on the other. It shows its readiness through two status bits:
- a ready-for-host bit;
- a direction bit that is high when data flows from the controller to the host.

It raises a service request for DMA or an interrupt when a programmed fill level is reached.

After reset the block behaves as a single-byte holding register. A configuration strobe switches it to a 16-byte buffered mode with a threshold of 1 to 15 bytes. In the command phase, host bytes go straight through as parameter bytes. Starting the execution phase empties the buffer. An overrun on a disk read or an underrun on a disk write ends the transfer and sets a sticky error flag. After a write underrun the block feeds zero bytes to the disk until the sector is complete, then requests a CRC. After a read overrun it waits for the host to drain the bytes still held before it signals that the result phase may begin.

Top module: `dhf_top`

## Requirements
- R1: After reset the block is in pass-through mode: capacity 1 byte, service request at 1 byte held. A second disk byte arriving in read execution while one byte is held, with no host read in that cycle, is an overrun.
- R2: A `cfg_load` pulse loads the buffered enable and the threshold. Buffered mode has a capacity of DEPTH (16) bytes. A threshold value of 0 is treated as 1.
- R3: In the command phase `rqm`=1 and `dio`=0. Each host write shows up in the same cycle on `param_valid`/`param_data`.
- R4: An `exec_start` pulse empties the buffer and enters the execution phase. `exec_rd`=1 selects disk-to-host, and `exec_rd`=0 selects host-to-disk.
- R5: In read execution, `srv_req` is high when the bytes held are at least the threshold, or when the transfer is aborted and bytes remain.
- R6: In write execution, `srv_req` is high when the free space is at least the threshold and no error has occurred.
- R7: `dio`=1 only in read execution. In read execution `rqm` is high when a byte is held. In write execution `rqm` is high when there is space and no error has occurred.
- R8: After a read overrun, further disk bytes are dropped and the host can still drain the held bytes. `res_ready` rises once the buffer is empty.
- R9: A write underrun gives the disk 0x00 from the failing request onward until the sector (SECTOR_LEN bytes since `exec_start`) is complete. `crc_req` then pulses high for one cycle in the cycle after the last byte, and `res_ready` goes high.
- R10: `err_flag` sets on overrun or underrun and stays set until a `cmd_start` pulse.
- R11: Bytes leave the buffer in the order they entered it, in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Load the mode configuration |
| cfg_buf_en | input | 1 | Buffered mode enable |
| cfg_thresh | input | 4 | Service threshold in bytes |
| cmd_start | input | 1 | Start of a new command (command phase) |
| exec_start | input | 1 | Enter the execution phase |
| exec_rd | input | 1 | Direction for the execution phase, 1 = disk to host |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 8 | Byte at the head of the buffer |
| rqm | output | 1 | Buffer ready for the host |
| dio | output | 1 | Direction, 1 = controller to host |
| srv_req | output | 1 | Service request |
| param_valid | output | 1 | Parameter byte strobe in the command phase |
| param_data | output | 8 | Parameter byte |
| dsk_rd_valid | input | 1 | Disk delivers a byte (read) |
| dsk_rd_data | input | 8 | Byte from the disk |
| dsk_wr_req | input | 1 | Disk takes a byte (write) |
| dsk_wr_data | output | 8 | Byte to the disk |
| crc_req | output | 1 | Request to append the CRC after padding |
| err_flag | output | 1 | Sticky overrun/underrun flag |
| res_ready | output | 1 | Aborted transfer wound up; result phase may begin |

## Verification
The assertions assume a well-behaved host:
- `cmd_start` and `exec_start` are never pulsed in the same cycle.
- The host reads or writes only while `rqm` is high.
- The disk side requests write bytes only during write execution.

The stimulus honours these assumptions in two ways. In its random sections it gates every host strobe on the model's view of readiness. It forces errors only through the disk-side strobes, which are the only inputs allowed to break the flow.

// File: rtl/dhf_pkg.sv
// Shared types for the disk host buffer.
package dhf_pkg;
    typedef enum logic {PH_CMD = 1'b0, PH_EXEC = 1'b1} phase_t;
endpackage

// File: rtl/dhf_store.sv
// Circular byte store with occupancy count.
// Assumes push is never asserted while full without a pop in the same cycle.
module dhf_store #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int OW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    output logic [OW-1:0] occ
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;

    // write the incoming byte into the slot at the write pointer
    always_ff @(posedge clk) begin
        if (push && !flush) mem[wp] <= wdata;
    end

    // pointers and count, flush empties the store
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp  <= '0;
            rp  <= '0;
            occ <= '0;
        end else begin
            if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            occ <= occ + OW'(push) - OW'(pop);
        end
    end

    assign rdata = mem[rp];
endmodule

// File: rtl/dhf_mode.sv
// Mode register: pass-through (capacity 1, threshold 1) after reset,
// buffered with a programmable threshold after a configuration load.
module dhf_mode #(
    parameter int DEPTH = 16,
    parameter int TW    = 4,
    localparam int OW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_load,
    input  logic          cfg_buf_en,
    input  logic [TW-1:0] cfg_thresh,
    output logic [OW-1:0] cap,
    output logic [OW-1:0] thr
);
    logic          buf_en;
    logic [TW-1:0] thr_q;

    // hold the configuration, reset returns to pass-through
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_en <= 1'b0;
            thr_q  <= TW'(1);
        end else if (cfg_load) begin
            buf_en <= cfg_buf_en;
            thr_q  <= (cfg_thresh == '0) ? TW'(1) : cfg_thresh;
        end
    end

    assign cap = buf_en ? OW'(DEPTH) : OW'(1);
    assign thr = buf_en ? OW'(thr_q) : OW'(1);
endmodule

// File: rtl/dhf_pad.sv
// Sector byte counter and zero-pad sequencer for write underrun.
// Counts every byte handed to the disk since clear. Once an underrun starts
// padding, it ends the padding on the last byte of the sector and pulses crc_req.
module dhf_pad #(
    parameter int SECTOR_LEN = 512,
    localparam int SW = $clog2(SECTOR_LEN)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic take,
    input  logic underrun,
    output logic pad_active,
    output logic pad_done,
    output logic crc_req
);
    logic [SW-1:0] sc;
    logic          pad_now;

    assign pad_now = pad_active || underrun;

    // track sector position and the padding state
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sc         <= '0;
            pad_active <= 1'b0;
            pad_done   <= 1'b0;
            crc_req    <= 1'b0;
        end else begin
            crc_req <= 1'b0;
            if (take) begin
                if (sc == SW'(SECTOR_LEN - 1)) begin
                    sc <= '0;
                    if (pad_now) begin
                        pad_active <= 1'b0;
                        pad_done   <= 1'b1;
                        crc_req    <= 1'b1;
                    end
                end else begin
                    sc <= sc + 1'b1;
                    if (underrun) pad_active <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dhf_top.sv
// Host-side data buffer of a disk controller: phase control, gating of
// host and disk strobes, error detection and the service request.
// Assumes the host strobes only while rqm is high.
module dhf_top #(
    parameter int DEPTH      = 16,
    parameter int TW         = 4,
    parameter int SECTOR_LEN = 512,
    localparam int OW        = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_load,
    input  logic          cfg_buf_en,
    input  logic [TW-1:0] cfg_thresh,
    input  logic          cmd_start,
    input  logic          exec_start,
    input  logic          exec_rd,
    input  logic          host_wr,
    input  logic [7:0]    host_wdata,
    input  logic          host_rd,
    output logic [7:0]    host_rdata,
    output logic          rqm,
    output logic          dio,
    output logic          srv_req,
    output logic          param_valid,
    output logic [7:0]    param_data,
    input  logic          dsk_rd_valid,
    input  logic [7:0]    dsk_rd_data,
    input  logic          dsk_wr_req,
    output logic [7:0]    dsk_wr_data,
    output logic          crc_req,
    output logic          err_flag,
    output logic          res_ready
);
    import dhf_pkg::*;

    phase_t        phase;
    logic          dir_rd;
    logic [OW-1:0] occ, cap, thr;
    logic [7:0]    head;
    logic          in_exec, rd_mode, wr_mode, empty, full;
    logic          host_pop, host_push, disk_push, disk_pop;
    logic          overrun, underrun, take;
    logic          pad_active, pad_done;

    dhf_mode #(.DEPTH(DEPTH), .TW(TW)) u_mode (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_buf_en(cfg_buf_en),
        .cfg_thresh(cfg_thresh), .cap(cap), .thr(thr)
    );

    dhf_store #(.DEPTH(DEPTH), .W(8)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(exec_start),
        .push(disk_push || host_push), .pop(host_pop || disk_pop),
        .wdata(dir_rd ? dsk_rd_data : host_wdata), .rdata(head), .occ(occ)
    );

    dhf_pad #(.SECTOR_LEN(SECTOR_LEN)) u_pad (
        .clk(clk), .rst_n(rst_n), .clear(exec_start), .take(take),
        .underrun(underrun), .pad_active(pad_active), .pad_done(pad_done),
        .crc_req(crc_req)
    );

    // phase and direction sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_CMD;
            dir_rd <= 1'b0;
        end else if (cmd_start) begin
            phase  <= PH_CMD;
        end else if (exec_start) begin
            phase  <= PH_EXEC;
            dir_rd <= exec_rd;
        end
    end

    // sticky error flag, cleared when a new command begins
    always_ff @(posedge clk) begin
        if (!rst_n || cmd_start) err_flag <= 1'b0;
        else if (overrun || underrun) err_flag <= 1'b1;
    end

    // strobe gating and error detection
    always_comb begin
        in_exec   = (phase == PH_EXEC);
        rd_mode   = in_exec && dir_rd;
        wr_mode   = in_exec && !dir_rd;
        empty     = (occ == '0);
        full      = (occ >= cap);
        host_pop  = rd_mode && host_rd && !empty;
        overrun   = rd_mode && !err_flag && dsk_rd_valid && full && !host_pop;
        disk_push = rd_mode && !err_flag && dsk_rd_valid && (!full || host_pop);
        underrun  = wr_mode && !err_flag && dsk_wr_req && empty;
        disk_pop  = wr_mode && !err_flag && dsk_wr_req && !empty;
        host_push = wr_mode && !err_flag && host_wr && !full && !underrun;
        take      = wr_mode && dsk_wr_req && !pad_done;
    end

    // host status, service request and data paths
    always_comb begin
        dio         = rd_mode;
        rqm         = !in_exec || (dir_rd ? !empty : (!full && !err_flag));
        if (rd_mode)      srv_req = (occ >= thr) || (err_flag && !empty);
        else if (wr_mode) srv_req = !err_flag && ((cap - occ) >= thr);
        else              srv_req = 1'b0;
        param_valid = !in_exec && host_wr;
        param_data  = host_wdata;
        host_rdata  = head;
        dsk_wr_data = (pad_active || underrun) ? 8'h00 : head;
        res_ready   = err_flag && in_exec && (dir_rd ? empty : pad_done);
    end
endmodule

// File: rtl/dhf_check.sv
// Protocol checker for dhf_top, attached by bind.
// Assumes cmd_start and exec_start never coincide.
module dhf_check #(
    parameter int OW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_exec,
    input logic          dir_rd,
    input logic          rqm,
    input logic          dio,
    input logic          exec_start,
    input logic          cmd_start,
    input logic          err_flag,
    input logic          pad_active,
    input logic          dsk_wr_req,
    input logic [7:0]    dsk_wr_data,
    input logic [OW-1:0] occ,
    input logic [OW-1:0] cap
);
    a_r3_cmd_status: assert property (@(posedge clk) disable iff (!rst_n)
        !in_exec |-> (rqm && !dio));
    a_r4_flush: assert property (@(posedge clk) disable iff (!rst_n)
        exec_start |=> (occ == '0));
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= cap);
    a_r9_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_active && dsk_wr_req) |-> (dsk_wr_data == 8'h00));
    a_r7_wr_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (in_exec && !dir_rd && err_flag) |-> !rqm);
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !cmd_start) |=> err_flag);
endmodule

bind dhf_top dhf_check #(.OW(OW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_exec(in_exec), .dir_rd(dir_rd),
    .rqm(rqm), .dio(dio), .exec_start(exec_start), .cmd_start(cmd_start),
    .err_flag(err_flag), .pad_active(pad_active), .dsk_wr_req(dsk_wr_req),
    .dsk_wr_data(dsk_wr_data), .occ(occ), .cap(cap)
);

// File: tb/dhf_top_test.sv
module dhf_top_test;
    localparam int SEC = 32;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       cfg_load = 0, cfg_buf_en = 0, cmd_start = 0, exec_start = 0, exec_rd = 0;
    logic [3:0] cfg_thresh = 0;
    logic       host_wr = 0, host_rd = 0, dsk_rd_valid = 0, dsk_wr_req = 0;
    logic [7:0] host_wdata = 0, dsk_rd_data = 0;
    logic [7:0] host_rdata, param_data, dsk_wr_data;
    logic       rqm, dio, srv_req, param_valid, crc_req, err_flag, res_ready;

    int checks = 0, fails = 0;
    byte unsigned q[$];

    always #4 clk = ~clk;

    dhf_top #(.SECTOR_LEN(SEC)) uut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one clock edge, then strobes drop and outputs settle
    task automatic tick();
        @(posedge clk);
        #1;
        {cfg_load, cmd_start, exec_start, host_wr, host_rd, dsk_rd_valid, dsk_wr_req} = '0;
        #1;
    endtask

    function automatic bit srv_rd(int n, int t);
        return n >= t;
    endfunction

    task automatic config_buf(input int t);
        cmd_start = 1; tick();
        cfg_load = 1; cfg_buf_en = 1; cfg_thresh = 4'(t); tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1 rst_n = 1; #1;
        chk(rqm && !dio, "R7 reset status", {rqm, dio}, 2);
        chk(!srv_req && !err_flag, "R1 reset quiet", {srv_req, err_flag}, 0);

        // R3 parameter pass-through
        host_wr = 1; host_wdata = 8'h5A; #1;
        chk(param_valid && param_data == 8'h5A, "R3 param", param_data, 8'h5A);
        tick();

        // R1 legacy read, single byte holding
        exec_start = 1; exec_rd = 1; tick();
        chk(!rqm && dio, "R7 read empty", {rqm, dio}, 1);
        dsk_rd_valid = 1; dsk_rd_data = 8'h11; tick();
        chk(rqm && srv_req && host_rdata == 8'h11, "R1 legacy one byte", host_rdata, 8'h11);
        dsk_rd_valid = 1; dsk_rd_data = 8'h22; tick();
        chk(err_flag && host_rdata == 8'h11, "R1 legacy overrun", {err_flag, host_rdata}, 256 + 8'h11);
        chk(!res_ready, "R8 wait drain", res_ready, 0);
        host_rd = 1; tick();
        chk(res_ready && !rqm, "R8 drained", {res_ready, rqm}, 2);
        cmd_start = 1; tick();
        chk(!err_flag, "R10 clear on command", err_flag, 0);

        // R6 write threshold 15
        config_buf(15);
        exec_start = 1; exec_rd = 0; tick();
        chk(srv_req && rqm && !dio, "R6 free 16", {srv_req, rqm, dio}, 6);
        q.delete();
        for (int i = 0; i < 16; i++) begin
            host_wr = 1; host_wdata = 8'($urandom); q.push_back(host_wdata); tick();
            chk(srv_req == ((16 - q.size()) >= 15), "R6 write srv", srv_req, (16 - q.size()) >= 15);
        end
        chk(!rqm, "R7 write full", rqm, 0);
        for (int i = 0; i < 16; i++) begin
            dsk_wr_req = 1; #1;
            chk(dsk_wr_data == q[0], "R11 write order", dsk_wr_data, q[0]);
            void'(q.pop_front()); tick();
        end

        // R9 underrun with padding
        cmd_start = 1; tick();
        exec_start = 1; exec_rd = 0; tick();
        for (int i = 0; i < 5; i++) begin
            host_wr = 1; host_wdata = 8'(8'hA0 + i); q.push_back(host_wdata); tick();
        end
        for (int i = 0; i < 5; i++) begin
            dsk_wr_req = 1; #1;
            chk(dsk_wr_data == q[0], "R11 pre-underrun data", dsk_wr_data, q[0]);
            void'(q.pop_front()); tick();
        end
        for (int i = 5; i < SEC; i++) begin
            dsk_wr_req = 1; host_wr = (i == 8); host_wdata = 8'hFF; #1;
            chk(dsk_wr_data == 8'h00, "R9 zero pad", dsk_wr_data, 0);
            tick();
            chk(err_flag && !rqm, "R10 underrun flag", {err_flag, rqm}, 2);
            chk(crc_req == (i == SEC - 1), "R9 crc timing", crc_req, i == SEC - 1);
        end
        chk(res_ready, "R9 result ready", res_ready, 1);
        tick();
        chk(!crc_req, "R9 crc single", crc_req, 0);

        // R5 random buffered read with several thresholds
        for (int b = 0; b < 3; b++) begin
            int t = (b == 0) ? 1 : (b == 1) ? 15 : 1 + int'($urandom % 15);
            config_buf(t);
            exec_start = 1; exec_rd = 1; tick();
            q.delete();
            for (int c = 0; c < 300; c++) begin
                bit p = ($urandom % 2) && q.size() < 16;
                bit r = ($urandom % 3 == 0) && q.size() > 0;
                if (r) begin
                    chk(host_rdata == q[0], "R11 read order", host_rdata, q[0]);
                    void'(q.pop_front());
                end
                host_rd = r;
                dsk_rd_valid = p; dsk_rd_data = 8'($urandom);
                if (p) q.push_back(dsk_rd_data);
                tick();
                chk(srv_req == srv_rd(q.size(), t), "R5 read srv", srv_req, srv_rd(q.size(), t));
                chk(rqm == (q.size() > 0), "R7 read rqm", rqm, q.size() > 0);
            end
            chk(!err_flag, "R10 no false error", err_flag, 0);
        end

        // R4 flush on execution entry
        dsk_rd_valid = 1; dsk_rd_data = 8'h33; tick();
        exec_start = 1; exec_rd = 1; tick();
        chk(!rqm && !srv_req, "R4 flush", {rqm, srv_req}, 0);

        // R8 forced read overrun with host drain, threshold 8
        config_buf(8);
        exec_start = 1; exec_rd = 1; tick();
        q.delete();
        for (int i = 0; i < 16; i++) begin
            dsk_rd_valid = 1; dsk_rd_data = 8'($urandom); q.push_back(dsk_rd_data); tick();
        end
        chk(srv_req, "R5 full srv", srv_req, 1);
        for (int i = 0; i < 3; i++) begin
            dsk_rd_valid = 1; dsk_rd_data = 8'hEE; tick();
        end
        chk(err_flag && rqm && !res_ready, "R8 overrun", {err_flag, rqm, res_ready}, 6);
        while (q.size() > 0) begin
            chk(host_rdata == q[0], "R8 drain data", host_rdata, q[0]);
            chk(srv_req, "R5 aborted srv", srv_req, 1);
            void'(q.pop_front());
            host_rd = 1; tick();
            chk(res_ready == (q.size() == 0), "R8 res timing", res_ready, q.size() == 0);
        end
        cmd_start = 1; tick();
        chk(!err_flag, "R10 cleared", err_flag, 0);

        // R2 threshold 0 behaves as 1
        config_buf(0);
        exec_start = 1; exec_rd = 1; tick();
        dsk_rd_valid = 1; dsk_rd_data = 8'h44; tick();
        chk(srv_req, "R2 thresh zero", srv_req, 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule